// File: doc/BRIEF.md
# Serial 1-0-1 Pattern Detector with Selectable Match Chaining

This block watches a serial bit stream, one bit per rising clock edge, and flags each place where the bits 1, 0, 1 arrive in that order. It is a Moore state machine. The match flag comes only from the present state, so it rises in the state period right after the edge that samples the final 1. It stays high for exactly one state period.

A static mode input sets what happens after a hit. In chaining mode, the final 1 of a match may also be the first 1 of the next match, so the stream 1,0,1,0,1 gives two hits. In fresh-start mode, every bit of a match is used up, and the search begins again with the bit that follows. The two modes share one machine. They differ only in where the hit state goes on a 0. The mode is treated as a level and should change only while reset is held.

Top module: `seq101_detector`

## Requirements
- R1: A synchronous active-high reset puts the machine in its idle state. `match_out` reads 0 in the state period after any reset edge. Bits seen before the reset never take part in a later match.
- R2: `match_out` is 1 only when the last three bits sampled since reset are 1, 0, 1, newest last. It rises in the state period right after the edge that samples the final 1.
- R3: `match_out` is never high for two state periods in a row.
- R4: With `chain_en` = 1 (chaining mode), a hit followed by the bits 0, 1 gives another hit. The stream 000101011011011 yields 000001010010010.
- R5: With `chain_en` = 0 (fresh-start mode), a hit followed by the bits 0, 1 gives no hit. The stream 000101011011011 yields 000001000010010.
- R6: In both modes, a hit followed by the bits 1, 0, 1 gives another hit, because a 1 after a hit moves to the seen-one state.
- R7: After two consecutive 0 bits, `match_out` stays 0 for the next three state periods.
- R8: In both modes, over any stream, `match_out` equals a bit-level reference. In fresh-start mode, a match counts only when none of its three bits belonged to the previous match.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock; one stream bit per edge |
| rst | input | 1 | Synchronous active-high reset to the idle state |
| bit_in | input | 1 | Serial data bit sampled on each rising edge |
| chain_en | input | 1 | 1 = chaining mode, 0 = fresh-start mode; static between resets |
| match_out | output | 1 | Moore flag, high for one state period after 1-0-1 completes |

## Verification
The cycle that matters most is the one after a hit. In that cycle the machine must present the hit and, on the same edge, choose its successor from the new bit and the mode. Streams are built so that 0,1 and 1,0,1 follow a hit directly. The outcome is judged per bit, in each mode, against a reference model that tracks how many bits have passed since reset and since the last match. A reset is also issued in the exact period in which the hit flag is high. The check is then that a following 0,1 does not chain into a false hit.

// File: rtl/seq101_pkg.sv
package seq101_pkg;

    localparam int unsigned STATE_W = 2;

    typedef enum logic [STATE_W-1:0] {
        ST_IDLE     = 2'd0,
        ST_ONE      = 2'd1,
        ST_ONE_ZERO = 2'd2,
        ST_HIT      = 2'd3
    } det_state_e;

    typedef enum logic {
        MODE_FRESH = 1'b0,
        MODE_CHAIN = 1'b1
    } det_mode_e;

    // Successor of the hit state: the only place the two modes differ.
    function automatic det_state_e leave_hit(input det_mode_e mode, input logic b);
        if (b) begin
            return ST_ONE;
        end
        return (mode == MODE_CHAIN) ? ST_ONE_ZERO : ST_IDLE;
    endfunction

    function automatic det_state_e step_state(input det_state_e cur,
                                              input logic b,
                                              input det_mode_e mode);
        det_state_e nxt;
        unique case (cur)
            ST_IDLE:     nxt = b ? ST_ONE : ST_IDLE;
            ST_ONE:      nxt = b ? ST_ONE : ST_ONE_ZERO;
            ST_ONE_ZERO: nxt = b ? ST_HIT : ST_IDLE;
            ST_HIT:      nxt = leave_hit(mode, b);
            default:     nxt = ST_IDLE;
        endcase
        return nxt;
    endfunction

    function automatic logic is_hit(input det_state_e s);
        return s == ST_HIT;
    endfunction

endpackage

// File: rtl/seq101_next_logic.sv
module seq101_next_logic
    import seq101_pkg::*;
(
    input  det_state_e cur_state,
    input  logic       data_bit,
    input  det_mode_e  mode,
    output det_state_e nxt_state
);
    always_comb begin
        nxt_state = step_state(cur_state, data_bit, mode);
    end
endmodule

// File: rtl/seq101_state_reg.sv
module seq101_state_reg
    import seq101_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  det_state_e nxt_state,
    output det_state_e cur_state
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cur_state <= ST_IDLE;
        end else begin
            cur_state <= nxt_state;
        end
    end
endmodule

// File: rtl/seq101_match_decode.sv
module seq101_match_decode
    import seq101_pkg::*;
(
    input  det_state_e cur_state,
    output logic       match
);
    always_comb begin
        match = is_hit(cur_state);
    end
endmodule

// File: rtl/seq101_detector.sv
module seq101_detector
    import seq101_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic bit_in,
    input  logic chain_en,
    output logic match_out
);
    det_state_e state_q;
    det_state_e state_d;
    det_mode_e  mode;

    assign mode = det_mode_e'(chain_en);

    seq101_next_logic u_next (
        .cur_state (state_q),
        .data_bit  (bit_in),
        .mode      (mode),
        .nxt_state (state_d)
    );

    seq101_state_reg u_sreg (
        .clk       (clk),
        .rst       (rst),
        .nxt_state (state_d),
        .cur_state (state_q)
    );

    seq101_match_decode u_dec (
        .cur_state (state_q),
        .match     (match_out)
    );
endmodule

// File: rtl/seq101_checker.sv
module seq101_checker (
    input logic clk,
    input logic rst,
    input logic bit_in,
    input logic chain_en,
    input logic match_out
);
    logic [2:0] hist_q;
    logic [1:0] fill_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hist_q <= 3'b000;
            fill_q <= 2'd0;
        end else begin
            hist_q <= {hist_q[1:0], bit_in};
            if (fill_q != 2'd3) begin
                fill_q <= fill_q + 2'd1;
            end
        end
    end

    p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !match_out);

    p_needs_pattern_r2: assert property (@(posedge clk) disable iff (rst)
        match_out |-> (hist_q == 3'b101 && fill_q == 2'd3));

    p_single_period_r3: assert property (@(posedge clk) disable iff (rst)
        match_out |=> !match_out);

    p_chain_reuse_r4: assert property (@(posedge clk) disable iff (rst)
        (match_out && chain_en && !bit_in) ##1 bit_in |=> match_out);

    p_fresh_no_reuse_r5: assert property (@(posedge clk) disable iff (rst)
        (match_out && !chain_en && !bit_in) ##1 bit_in |=> !match_out);

    p_one_restarts_r6: assert property (@(posedge clk) disable iff (rst)
        (match_out && bit_in) ##1 !bit_in ##1 bit_in |=> match_out);

    p_zeros_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        !bit_in ##1 !bit_in |=> !match_out ##1 !match_out ##1 !match_out);
endmodule

bind seq101_detector seq101_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .bit_in    (bit_in),
    .chain_en  (chain_en),
    .match_out (match_out)
);

// File: tb/sim_seq101_detector.sv
`timescale 1ns/1ps
module sim_seq101_detector;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bit_in = 1'b0;
    logic chain_en = 1'b0;
    logic match_out;

    int checks = 0;
    int errors = 0;

    // reference model state
    logic [2:0] m_hist;
    int         m_since_rst;
    int         m_since_hit;

    always #10 clk = ~clk;

    seq101_detector u0 (
        .clk       (clk),
        .rst       (rst),
        .bit_in    (bit_in),
        .chain_en  (chain_en),
        .match_out (match_out)
    );

    task automatic chk(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: match_out=%b expected %b", tag, act, exp);
        end
    endtask

    task automatic model_clear();
        m_hist      = 3'b000;
        m_since_rst = 0;
        m_since_hit = 3;
    endtask

    function automatic logic model_step(input logic b, input logic chain);
        logic hit;
        m_hist = {m_hist[1:0], b};
        if (m_since_rst < 3) m_since_rst++;
        if (m_since_hit < 3) m_since_hit++;
        hit = (m_hist == 3'b101) && (m_since_rst >= 3) && (chain || m_since_hit >= 3);
        if (hit) m_since_hit = 0;
        return hit;
    endfunction

    task automatic do_reset(input logic mode);
        rst      = 1'b1;
        chain_en = mode;
        bit_in   = 1'b1;
        @(posedge clk);
        @(posedge clk);
        #5;
        chk(match_out, 1'b0, "R1 reset clears flag");
        rst = 1'b0;
        model_clear();
    endtask

    // drive one bit, sample the flag after the edge that takes it
    task automatic push(input logic b, output logic z);
        bit_in = b;
        @(posedge clk);
        #5;
        z = match_out;
    endtask

    task automatic t_doc_stream(input logic mode, input logic [14:0] exp_z, input string tag);
        logic [14:0] stim;
        logic z;
        stim = 15'b000101011011011;
        do_reset(mode);
        for (int i = 14; i >= 0; i--) begin
            push(stim[i], z);
            chk(z, exp_z[i], tag);
            chk(z, model_step(stim[i], mode), "R8 doc stream vs model");
        end
    endtask

    task automatic t_after_hit(input logic mode);
        logic z;
        do_reset(mode);
        push(1'b1, z); push(1'b0, z); push(1'b1, z);
        chk(z, 1'b1, "R2 hit after 1,0,1");
        push(1'b1, z);
        chk(z, 1'b0, "R3 flag lasts one period");
        push(1'b0, z); push(1'b1, z);
        chk(z, 1'b1, "R6 hit then 1,0,1 hits again");
        push(1'b0, z); push(1'b0, z);
        push(1'b1, z);
        chk(z, 1'b0, "R7 quiet after two zeros");
        push(1'b1, z);
        chk(z, 1'b0, "R7 quiet after two zeros (2)");
    endtask

    task automatic t_reset_in_hit();
        logic z;
        do_reset(1'b1);
        push(1'b1, z); push(1'b0, z); push(1'b1, z);
        chk(z, 1'b1, "R2 hit before reset");
        rst    = 1'b1;
        bit_in = 1'b0;
        @(posedge clk);
        #5;
        chk(match_out, 1'b0, "R1 reset during hit");
        rst = 1'b0;
        push(1'b1, z);
        chk(z, 1'b0, "R1 no chain across reset");
        push(1'b0, z); push(1'b1, z);
        chk(z, 1'b1, "R1 fresh pattern after reset");
    endtask

    task automatic t_random(input logic mode, input logic [15:0] seed, input string tag);
        logic [15:0] lfsr;
        logic z;
        lfsr = seed;
        do_reset(mode);
        for (int i = 0; i < 300; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            push(lfsr[0] | lfsr[3], z);
            chk(z, model_step(lfsr[0] | lfsr[3], mode), tag);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete, actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        model_clear();
        t_doc_stream(1'b0, 15'b000001000010010, "R5 fresh-start doc stream");
        t_doc_stream(1'b1, 15'b000001010010010, "R4 chaining doc stream");
        t_after_hit(1'b0);
        t_after_hit(1'b1);
        t_reset_in_hit();
        t_random(1'b0, 16'hACE1, "R8 fresh-start random vs model");
        t_random(1'b1, 16'h3B07, "R8 chaining random vs model");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule